// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does this by reading two levels of translation entries from memory. A requester supplies the virtual address, the direction of the access, an enable for translation and the base of the top-level directory, then pulses `start`. When translation is enabled, the walker makes two reads through a request/acknowledge memory port. The first read fetches the directory entry selected by the upper ten address bits. The second fetches the table entry selected by the middle ten bits. The walker then reports the physical page with the untouched 12-bit offset, or a page fault whose code follows the access direction.

Each entry is 32 bits. Bits 31:12 hold the page-aligned base of the next level, bit 1 grants write permission and bit 0 marks the entry valid. Only the final-level entry decides write permission. When translation is disabled, the address passes through unchanged without any memory traffic. Results stay on the outputs until the next walk starts, and `done` marks the single cycle in which they become valid.

Top module: `pgwalk`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req`, `done`, `fault` and `writable` are low, and `paddr` and `fault_code` are zero.
- R2: A `start` while idle with `mmu_on` low raises `done` in the next cycle, with `paddr` equal to `vaddr`, `writable` high, no fault and no memory read.
- R3: The first read is at address (`dir_base` with bits 11:0 cleared) + 4 × `vaddr[31:22]`. `mem_req` and `mem_addr` stay steady until `mem_ack` is sampled high.
- R4: A directory entry with bit 0 clear ends the walk as a fault after exactly one memory read.
- R5: The second read is at (directory entry with bits 11:0 cleared) + 4 × `vaddr[21:12]`.
- R6: A table entry with bit 0 clear ends the walk as a fault after two memory reads.
- R7: On success, `paddr` is table entry bits 31:12 followed by `vaddr[11:0]`, and `writable` copies table entry bit 1.
- R8: A write access to a valid page whose bit 1 is clear faults. A read access to the same page succeeds with `writable` low.
- R9: On a fault, `fault` is high, `fault_code` is 2 for a read and 3 for a write, `paddr` holds the virtual address and `writable` is low. Without a fault, `fault_code` is 0.
- R10: `done` is high for exactly one cycle per walk. The result outputs do not change between walks.
- R11: A `start` pulse while a walk is in progress is ignored. The running walk completes unchanged.
- R12: `vaddr`, `is_write` and `dir_base` are captured at `start`. Later changes to them during the walk do not affect the reads or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation (accepted when idle) |
| vaddr | input | 32 | Virtual address |
| is_write | input | 1 | 1 = write access, 0 = read access |
| mmu_on | input | 1 | Translation enable |
| dir_base | input | 32 | Directory base address (bits 11:0 ignored) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| paddr | output | 32 | Physical address, or faulting virtual address |
| writable | output | 1 | Page may be written |
| fault | output | 1 | Translation failed |
| fault_code | output | 3 | 2 = read fault, 3 = write fault, 0 = none |

## Verification
The hardest situation to reach from the ports is a walk that is disturbed while it waits on slow memory. In that case a new `start`, a different virtual address and a different directory base all arrive between the two reads. To reach it, the bench stretches the acknowledge latency to several cycles and toggles those inputs while `busy` is high. Its behavioural model keeps the values captured at the start. The bench also places entries at index 1023 of both levels, covering the top end of the address arithmetic. It also pairs a read and a write to the same read-only page, so that only the access direction separates success from fault.

// File: rtl/pgwalk.sv
module pgwalk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VA_W-1:0] vaddr,
  input  logic            is_write,
  input  logic            mmu_on,
  input  logic [VA_W-1:0] dir_base,
  output logic            mem_req,
  output logic [VA_W-1:0] mem_addr,
  input  logic            mem_ack,
  input  logic [VA_W-1:0] mem_rdata,
  output logic            busy,
  output logic            done,
  output logic [VA_W-1:0] paddr,
  output logic            writable,
  output logic            fault,
  output logic [2:0]      fault_code
);
  localparam int TAG_W   = VA_W - OFF_W;
  localparam int DIR_LSB = OFF_W + IDX_W;
  localparam int PAD_W   = VA_W - IDX_W - 2;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_TBL, S_DONE} st_t;

  st_t             st;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic [TAG_W-1:0] dbase_q, tbase_q;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] base;
  logic            ent_ok, perm_ok;

  assign busy    = st != S_IDLE;
  assign done    = st == S_DONE;
  assign mem_req = (st == S_DIR) || (st == S_TBL);
  assign idx     = (st == S_TBL) ? va_q[DIR_LSB-1:OFF_W] : va_q[VA_W-1:DIR_LSB];
  assign base    = (st == S_TBL) ? tbase_q : dbase_q;
  assign mem_addr = {base, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, idx, 2'b00};
  assign ent_ok  = mem_rdata[0];
  assign perm_ok = mem_rdata[1] || !wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      dbase_q    <= '0;
      tbase_q    <= '0;
      paddr      <= '0;
      writable   <= 1'b0;
      fault      <= 1'b0;
      fault_code <= 3'd0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          va_q    <= vaddr;
          wr_q    <= is_write;
          dbase_q <= dir_base[VA_W-1:OFF_W];
          if (mmu_on) begin
            st <= S_DIR;
          end else begin
            paddr      <= vaddr;
            writable   <= 1'b1;
            fault      <= 1'b0;
            fault_code <= 3'd0;
            st         <= S_DONE;
          end
        end
        S_DIR: if (mem_ack) begin
          if (ent_ok) begin
            tbase_q <= mem_rdata[VA_W-1:OFF_W];
            st      <= S_TBL;
          end else begin
            paddr      <= va_q;
            writable   <= 1'b0;
            fault      <= 1'b1;
            fault_code <= wr_q ? 3'd3 : 3'd2;
            st         <= S_DONE;
          end
        end
        S_TBL: if (mem_ack) begin
          if (ent_ok && perm_ok) begin
            paddr      <= {mem_rdata[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
            writable   <= mem_rdata[1];
            fault      <= 1'b0;
            fault_code <= 3'd0;
          end else begin
            paddr      <= va_q;
            writable   <= 1'b0;
            fault      <= 1'b1;
            fault_code <= wr_q ? 3'd3 : 3'd2;
          end
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pgwalk_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [VA_W-1:0] vaddr,
  input logic            is_write,
  input logic            mmu_on,
  input logic [VA_W-1:0] dir_base,
  input logic            mem_req,
  input logic [VA_W-1:0] mem_addr,
  input logic            mem_ack,
  input logic [VA_W-1:0] mem_rdata,
  input logic            busy,
  input logic            done,
  input logic [VA_W-1:0] paddr,
  input logic            writable,
  input logic            fault,
  input logic [2:0]      fault_code
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !done);

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !mmu_on |=> done && !mem_req && writable && !fault && paddr == $past(vaddr));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  p_rdata_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack && mem_req |-> !$isunknown({mem_rdata, dir_base, is_write}));

  p_dir_absent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack && mem_req && !mem_rdata[0] && $past(!mem_req) |=> done && fault);

  p_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> (fault_code == 3'd2 || fault_code == 3'd3) && !writable);

  p_nocode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault |-> fault_code == 3'd0);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(paddr) && $stable(fault) && $stable(writable) && $stable(fault_code));
endmodule

bind pgwalk pgwalk_chk #(.VA_W(VA_W)) u_chk (.*);

// File: tb/tb_pgwalk.sv
module tb_pgwalk;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] vaddr = '0;
  logic        is_write = 1'b0;
  logic        mmu_on = 1'b0;
  logic [31:0] dir_base = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, done, writable, fault;
  logic [31:0] paddr;
  logic [2:0]  fault_code;

  pgwalk dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [31:0] pm [logic [31:0]];
  int lat = 0, ack_cnt = 0, nreads = 0;
  string tag = "R1";
  bit live = 0;

  // reference model state
  int          m_ph = 0;
  logic [31:0] m_va, m_db, m_tb, m_pa;
  logic        m_wr, m_w, m_f;
  logic [2:0]  m_fc;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pm.exists(a) ? pm[a] : 32'h0;
  endfunction

  task automatic m_fail();
    m_pa = m_va; m_w = 0; m_f = 1; m_fc = m_wr ? 3'd3 : 3'd2; m_ph = 3;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_va = 0; m_db = 0; m_tb = 0; m_pa = 0;
      m_wr = 0; m_w = 0; m_f = 0; m_fc = 0;
    end else begin
      case (m_ph)
        0: if (start) begin
          m_va = vaddr; m_wr = is_write; m_db = dir_base & 32'hFFFF_F000;
          if (mmu_on) m_ph = 1;
          else begin m_pa = vaddr; m_w = 1; m_f = 0; m_fc = 0; m_ph = 3; end
        end
        1: if (mem_ack) begin
          if (mem_rdata[0]) begin m_tb = mem_rdata & 32'hFFFF_F000; m_ph = 2; end
          else m_fail();
        end
        2: if (mem_ack) begin
          if (!mem_rdata[0] || (m_wr && !mem_rdata[1])) m_fail();
          else begin
            m_pa = (mem_rdata & 32'hFFFF_F000) | (m_va & 32'h0000_0FFF);
            m_w = mem_rdata[1]; m_f = 0; m_fc = 0; m_ph = 3;
          end
        end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk("R3", "busy", busy, m_ph != 0);
      chk("R3", "mem_req", mem_req, m_ph == 1 || m_ph == 2);
      chk("R10", "done", done, m_ph == 3);
      if (m_ph == 1) chk("R3", "dir addr", mem_addr, m_db + (m_va >> 22) * 4);
      if (m_ph == 2) chk("R5", "tbl addr", mem_addr, m_tb + ((m_va >> 12) & 32'h3FF) * 4);
      if (m_ph == 3) begin
        chk(tag, "paddr", paddr, m_pa);
        chk(tag, "writable", writable, m_w);
        chk(m_f ? "R9" : tag, "fault", fault, m_f);
        chk(m_f ? "R9" : tag, "fault_code", fault_code, m_fc);
      end else if (m_ph == 0) begin
        chk("R10", "held paddr", paddr, m_pa);
        chk("R10", "held fault", fault, m_f);
      end
    end
    if (mem_req) begin
      if (ack_cnt >= lat) begin
        mem_ack = 1; mem_rdata = rd(mem_addr); ack_cnt = 0; nreads++;
      end else begin
        mem_ack = 0; ack_cnt++;
      end
    end else begin
      mem_ack = 0; ack_cnt = 0;
    end
  end

  task automatic walk(input logic [31:0] va, input logic wr, input logic mmu,
                      input logic [31:0] base, input int l, input string t,
                      input int exp_rd, input bit poke);
    @(negedge clk);
    tag = t; lat = l; nreads = 0;
    vaddr = va; is_write = wr; mmu_on = mmu; dir_base = base; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (3) begin
        vaddr = ~va; is_write = ~wr; dir_base = 32'h0BAD_0000; start = 1;
        @(negedge clk);
      end
      start = 0;
    end
    while (!done) @(negedge clk);
    chk(t, "read count", nreads, exp_rd);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    pm[32'h0010_0004] = 32'h0020_0001;
    pm[32'h0020_000C] = 32'h0ABC_D003;
    pm[32'h0020_0014] = 32'h0123_4001;
    pm[32'h0010_0008] = 32'h0000_0002;
    pm[32'h0020_001C] = 32'h0555_5002;
    pm[32'h0010_0FFC] = 32'h0030_0003;
    pm[32'h0030_0FFC] = 32'hFFFF_F003;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "mem_req", mem_req, 0);
    chk("R1", "done", done, 0);
    chk("R1", "fault", fault, 0);
    chk("R1", "writable", writable, 0);
    chk("R1", "paddr", paddr, 0);
    chk("R1", "fault_code", fault_code, 0);
    live = 1;

    walk(32'h1234_5678, 1'b1, 1'b0, 32'h0010_0000, 0, "R2", 0, 0);
    walk(32'h0040_3ABC, 1'b0, 1'b1, 32'h0010_0000, 0, "R7", 2, 0);
    walk(32'h0040_3ABC, 1'b1, 1'b1, 32'h0010_0123, 1, "R7", 2, 0);
    walk(32'h0040_5123, 1'b0, 1'b1, 32'h0010_0000, 0, "R8", 2, 0);
    walk(32'h0040_5123, 1'b1, 1'b1, 32'h0010_0000, 2, "R8", 2, 0);
    walk(32'h0080_0010, 1'b0, 1'b1, 32'h0010_0000, 0, "R4", 1, 0);
    walk(32'h0080_0010, 1'b1, 1'b1, 32'h0010_0000, 1, "R4", 1, 0);
    walk(32'h0040_7FFF, 1'b0, 1'b1, 32'h0010_0000, 0, "R6", 2, 0);
    walk(32'h0040_7FFF, 1'b1, 1'b1, 32'h0010_0000, 3, "R6", 2, 0);
    walk(32'hFFFF_FFFF, 1'b1, 1'b1, 32'h0010_0000, 0, "R5", 2, 0);
    walk(32'h0040_3ABC, 1'b0, 1'b1, 32'h0010_0000, 3, "R11", 2, 1);
    walk(32'h0040_5123, 1'b1, 1'b1, 32'h0010_0000, 4, "R12", 2, 1);
    walk(32'h0040_3ABC, 1'b1, 1'b0, 32'h0010_0000, 0, "R2", 0, 0);
    repeat (4) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule